// File: doc/BRIEF.md
# Uniform NTT-Domain Rejection Sampler

This block builds one polynomial of 256 coefficients in the number-theoretic-transform domain. It draws candidates from the output stream of an extendable-output function and keeps only those below the modulus 3329. An external permutation engine hands it one 1344-bit squeeze block at a time. The sampler stores the block and reads it three bytes at a time, from the lowest byte upward. Each three-byte group gives two 12-bit candidates, and the sampler judges one candidate per clock cycle.

A new block is requested only after all 56 groups of the current block have been used. The stream is therefore read the same way a conforming sampler reads it, with no bytes lost between requests. Accepted coefficients leave one per cycle, each with its position in the polynomial. When the last coefficient leaves, `done_o` marks the end of the polynomial. The environment polls `idle_o` before it starts the next polynomial, because the time taken depends on how many candidates are rejected and on how quickly blocks arrive.

Top module: `ntt_rej_sampler`

## Requirements
- R1: While reset is held and in the first cycle after it, `idle_o` is 1 and `blk_req_o`, `coef_valid_o` and `done_o` are 0.
- R2: When `start_i` is high while idle, `blk_req_o` rises on the next cycle. It stays high until a cycle in which `blk_valid_i` is high; `blk_data_i` is captured in that cycle, and `blk_req_o` is low in the cycle after.
- R3: Group g of a block is bits [24g+23:24g]. Groups are used in ascending order, g = 0 to 55.
- R4: Within group g, candidate A is bits [24g+11:24g]. That is the low byte plus the low nibble of the middle byte, shifted left by 8. Candidate B is bits [24g+23:24g+12]. That is the high nibble of the middle byte plus the top byte, shifted left by 4. A is judged before B.
- R5: A candidate is emitted on `coef_o` only if it is below 3329. A value of 3328 is kept and a value of 3329 is dropped. Rejected candidates produce no `coef_valid_o`.
- R6: Each run emits exactly 256 coefficients. Their `coef_idx_o` values are 0, 1, …, 255, in the order in which the candidates were judged.
- R7: A block is walked in exactly 112 cycles, one per candidate. The next `blk_req_o` rises only after the last candidate of group 55 has been judged. The cycle count from capture to the next request is 112 low cycles of `blk_req_o`.
- R8: `done_o` is high for exactly one cycle, in the same cycle as the coefficient with index 255. After that, no further candidate is emitted, including the second candidate of the same group. No further block is requested.
- R9: `start_i` has no effect while the sampler is not idle. `blk_valid_i` has no effect while `blk_req_o` is low.
- R10: `idle_o` is low from the cycle after an accepted `start_i` until `done_o`. It is high again in the cycle after `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin sampling one polynomial (honoured only while idle) |
| blk_valid_i | input | 1 | A squeeze block is present on `blk_data_i` |
| blk_data_i | input | 1344 | One rate block of squeeze output |
| blk_req_o | output | 1 | Sampler is waiting for the next squeeze block |
| coef_valid_o | output | 1 | `coef_o` and `coef_idx_o` carry an accepted coefficient |
| coef_idx_o | output | 8 | Position of the coefficient in the polynomial |
| coef_o | output | 12 | Accepted coefficient, below 3329 |
| done_o | output | 1 | Final coefficient of the polynomial is leaving |
| idle_o | output | 1 | Sampler is ready to accept `start_i` |

## Verification
The critical case is when acceptance of the 256th coefficient falls in the same cycle as exhaustion of the block, which would normally trigger a new request. The bench provokes this with a third block whose first 40 groups all reject, so that the final accept is candidate B of group 55. It then judges that `done_o` coincides with index 255, that no block request follows, and that exactly three blocks were consumed. A second same-cycle conflict arises when the final accept is candidate A of a group whose candidate B would also be accepted. That case is built from a pattern that accepts an odd number of candidates per block, and the bench checks that no 257th coefficient appears.

// File: rtl/rs_pkg.sv
// Package: rs_pkg
// Shared defaults and the controller state type for the rejection sampler.
// Assumes: the defaults describe a 1344-bit rate, 12-bit candidates and a
// 3329 modulus; modules take them as parameter defaults and may override.
package rs_pkg;

    localparam int RS_RATE_BITS = 1344;
    localparam int RS_COEF_W    = 12;
    localparam int RS_MODULUS   = 3329;
    localparam int RS_N_COEF    = 256;

    // Controller phases: waiting, asking for a block, walking it, finishing.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WALK  = 2'd2,
        ST_FIN   = 2'd3
    } rs_state_e;

endpackage

// File: rtl/rs_block_buf.sv
// Module: rs_block_buf
// Holds one squeeze block and presents the group that the pointer names.
// Assumes: load_i is only raised by the controller during a granted fetch,
// and ptr_i never exceeds NUM_GRP-1 (checked below).
module rs_block_buf #(
    parameter int RATE_BITS = rs_pkg::RS_RATE_BITS,
    parameter int GRP_BITS  = 2 * rs_pkg::RS_COEF_W,
    localparam int NUM_GRP  = RATE_BITS / GRP_BITS,
    localparam int PTR_W    = $clog2(NUM_GRP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [RATE_BITS-1:0] data_i,
    input  logic [PTR_W-1:0]     ptr_i,
    output logic [GRP_BITS-1:0]  grp_o
);

    logic [RATE_BITS-1:0] blk_q;
    logic [GRP_BITS-1:0]  grp_arr [NUM_GRP];

    // Capture the offered block when the controller grants the fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else if (load_i) begin
            blk_q <= data_i;
        end
    end

    // Slice the stored block into groups, lowest bytes first.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_slice
        assign grp_arr[g] = blk_q[g*GRP_BITS +: GRP_BITS];
    end

    // Present the group named by the walk pointer.
    always_comb begin
        grp_o = grp_arr[ptr_i];
    end

    AST_PTR_IN_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_i < PTR_W'(NUM_GRP)); // R3

endmodule

// File: rtl/rs_cand_split.sv
// Module: rs_cand_split
// Picks one 12-bit candidate out of a three-byte group and judges it.
// Assumes: the group is exactly two candidates wide; half_i = 0 selects the
// low candidate (judged first), half_i = 1 the high one.
module rs_cand_split #(
    parameter int COEF_W  = rs_pkg::RS_COEF_W,
    parameter int MODULUS = rs_pkg::RS_MODULUS
) (
    input  logic [2*COEF_W-1:0] grp_i,
    input  logic                half_i,
    output logic [COEF_W-1:0]   cand_o,
    output logic                ok_o
);

    logic [COEF_W-1:0] cand_lo;
    logic [COEF_W-1:0] cand_hi;

    // Low candidate: first byte plus low nibble of the middle byte on top;
    // high candidate: high nibble of the middle byte plus the last byte.
    always_comb begin
        cand_lo = grp_i[COEF_W-1:0];
        cand_hi = grp_i[2*COEF_W-1:COEF_W];
    end

    // Choose the candidate for this cycle and compare it with the modulus.
    always_comb begin
        cand_o = half_i ? cand_hi : cand_lo;
        ok_o   = (cand_o < COEF_W'(MODULUS));
    end

endmodule

// File: rtl/rs_ctrl.sv
// Module: rs_ctrl
// Sequencer for the sampler: asks for blocks, walks the groups one
// candidate per cycle, counts accepted coefficients and drives the outputs.
// Assumes: cand_i/cand_ok_i come combinationally from the stored block at
// (ptr_o, half_o); a block is only captured while blk_req_o is high.
module rs_ctrl #(
    parameter int NUM_GRP  = 56,
    parameter int N_COEF   = rs_pkg::RS_N_COEF,
    parameter int COEF_W   = rs_pkg::RS_COEF_W,
    localparam int PTR_W   = $clog2(NUM_GRP),
    localparam int IDX_W   = $clog2(N_COEF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              blk_valid_i,
    input  logic [COEF_W-1:0] cand_i,
    input  logic              cand_ok_i,
    output logic              load_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              half_o,
    output logic              blk_req_o,
    output logic              coef_valid_o,
    output logic [IDX_W-1:0]  coef_idx_o,
    output logic [COEF_W-1:0] coef_o,
    output logic              done_o,
    output logic              idle_o
);

    import rs_pkg::*;

    rs_state_e         st_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              half_q;
    logic [IDX_W-1:0]  cnt_q;
    logic              vld_q;
    logic [IDX_W-1:0]  idx_q;
    logic [COEF_W-1:0] coef_q;

    logic last_slot;
    logic take;
    logic final_take;

    // Decode the events of this cycle from the state and the candidate.
    always_comb begin
        last_slot  = half_q && (ptr_q == PTR_W'(NUM_GRP - 1));
        take       = (st_q == ST_WALK) && cand_ok_i;
        final_take = take && (cnt_q == IDX_W'(N_COEF - 1));
        load_o     = (st_q == ST_FETCH) && blk_valid_i;
    end

    // Phase sequencing: the final accept wins over block exhaustion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  if (start_i)     st_q <= ST_FETCH;
                ST_FETCH: if (blk_valid_i) st_q <= ST_WALK;
                ST_WALK: begin
                    if (final_take)     st_q <= ST_FIN;
                    else if (last_slot) st_q <= ST_FETCH;
                end
                ST_FIN:   st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // Group pointer and candidate half: rewound on load, stepped per walk cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            half_q <= 1'b0;
        end else if (load_o) begin
            ptr_q  <= '0;
            half_q <= 1'b0;
        end else if (st_q == ST_WALK) begin
            half_q <= ~half_q;
            if (half_q) begin
                ptr_q <= last_slot ? '0 : ptr_q + PTR_W'(1);
            end
        end
    end

    // Accepted-coefficient counter, cleared when a run starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (st_q == ST_IDLE && start_i) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + IDX_W'(1);
        end
    end

    // Output register for accepted coefficients and their index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            idx_q  <= '0;
            coef_q <= '0;
        end else begin
            vld_q <= take;
            if (take) begin
                idx_q  <= cnt_q;
                coef_q <= cand_i;
            end
        end
    end

    // Drive ports from the registered state.
    always_comb begin
        ptr_o        = ptr_q;
        half_o       = half_q;
        blk_req_o    = (st_q == ST_FETCH);
        done_o       = (st_q == ST_FIN);
        idle_o       = (st_q == ST_IDLE);
        coef_valid_o = vld_q;
        coef_idx_o   = idx_q;
        coef_o       = coef_q;
    end

    AST_IDLE_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> (!blk_req_o && !done_o)); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req_o && !blk_valid_i) |=> blk_req_o); // R2

    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req_o && blk_valid_i) |=> (!blk_req_o && ptr_q == '0 && !half_q)); // R2

    AST_REQ_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blk_req_o) |-> ($past(st_q) == ST_IDLE ||
                              ($past(ptr_q) == PTR_W'(NUM_GRP - 1) && $past(half_q)))); // R7

    AST_DONE_WITH_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (coef_valid_o && coef_idx_o == IDX_W'(N_COEF - 1))); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && idle_o && !coef_valid_o)); // R8

    AST_IDX_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_valid_o && take) |=> (coef_idx_o == $past(coef_idx_o) + IDX_W'(1))); // R6

    AST_STRAY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WALK && blk_valid_i && !last_slot && !final_take)
            |=> (st_q == ST_WALK && half_q != $past(half_q))); // R9

endmodule

// File: rtl/ntt_rej_sampler.sv
// Module: ntt_rej_sampler
// Top of the uniform NTT-domain rejection sampler: one stored squeeze
// block, a candidate splitter and the sequencer.
// Assumes: the environment answers blk_req_o with blk_valid_i and a full
// rate block, and polls idle_o before issuing the next start_i.
module ntt_rej_sampler #(
    parameter int RATE_BITS = rs_pkg::RS_RATE_BITS,
    parameter int COEF_W    = rs_pkg::RS_COEF_W,
    parameter int MODULUS   = rs_pkg::RS_MODULUS,
    parameter int N_COEF    = rs_pkg::RS_N_COEF,
    localparam int GRP_BITS = 2 * COEF_W,
    localparam int NUM_GRP  = RATE_BITS / GRP_BITS,
    localparam int PTR_W    = $clog2(NUM_GRP),
    localparam int IDX_W    = $clog2(N_COEF)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 blk_valid_i,
    input  logic [RATE_BITS-1:0] blk_data_i,
    output logic                 blk_req_o,
    output logic                 coef_valid_o,
    output logic [IDX_W-1:0]     coef_idx_o,
    output logic [COEF_W-1:0]    coef_o,
    output logic                 done_o,
    output logic                 idle_o
);

    logic                load;
    logic [PTR_W-1:0]    ptr;
    logic                half;
    logic [GRP_BITS-1:0] grp;
    logic [COEF_W-1:0]   cand;
    logic                cand_ok;

    rs_block_buf #(
        .RATE_BITS (RATE_BITS),
        .GRP_BITS  (GRP_BITS)
    ) u_buf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .data_i (blk_data_i),
        .ptr_i  (ptr),
        .grp_o  (grp)
    );

    rs_cand_split #(
        .COEF_W  (COEF_W),
        .MODULUS (MODULUS)
    ) u_split (
        .grp_i  (grp),
        .half_i (half),
        .cand_o (cand),
        .ok_o   (cand_ok)
    );

    rs_ctrl #(
        .NUM_GRP (NUM_GRP),
        .N_COEF  (N_COEF),
        .COEF_W  (COEF_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .blk_valid_i  (blk_valid_i),
        .cand_i       (cand),
        .cand_ok_i    (cand_ok),
        .load_o       (load),
        .ptr_o        (ptr),
        .half_o       (half),
        .blk_req_o    (blk_req_o),
        .coef_valid_o (coef_valid_o),
        .coef_idx_o   (coef_idx_o),
        .coef_o       (coef_o),
        .done_o       (done_o),
        .idle_o       (idle_o)
    );

    AST_COEF_BELOW_Q: assert property (@(posedge clk) disable iff (!rst_n)
        coef_valid_o |-> (coef_o < COEF_W'(MODULUS))); // R5

    AST_NO_REQ_WHILE_OUT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !blk_req_o); // R8

endmodule

// File: tb/sim_ntt_rej_sampler.sv
module sim_ntt_rej_sampler;

    localparam int RATE  = 1344;
    localparam int NGRP  = 56;
    localparam int Q     = 3329;
    localparam int NCOEF = 256;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             blk_valid_i;
    logic [RATE-1:0]  blk_data_i;
    logic             blk_req_o;
    logic             coef_valid_o;
    logic [7:0]       coef_idx_o;
    logic [11:0]      coef_o;
    logic             done_o;
    logic             idle_o;

    always #10 clk = ~clk;  // 50 MHz

    ntt_rej_sampler u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .blk_valid_i  (blk_valid_i),
        .blk_data_i   (blk_data_i),
        .blk_req_o    (blk_req_o),
        .coef_valid_o (coef_valid_o),
        .coef_idx_o   (coef_idx_o),
        .coef_o       (coef_o),
        .done_o       (done_o),
        .idle_o       (idle_o)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [RATE-1:0] blocks [8];
    int              n_blocks = 0;

    // responder state
    logic            resp_valid = 1'b0;
    logic [RATE-1:0] resp_data = '0;
    logic            spur_valid = 1'b0;
    int              resp_delay = 0;
    int              wait_ctr = 0;
    int              served = 0;

    assign blk_valid_i = resp_valid | spur_valid;
    assign blk_data_i  = resp_valid ? resp_data : {RATE{1'b1}};

    // collector state
    int          cyc = 0;
    int          got_n = 0;
    logic [11:0] got_coef [NCOEF];
    logic [7:0]  got_idx  [NCOEF];
    int          last_coef_cyc = -1;
    int          done_n = 0;
    int          done_cyc = -2;
    int          gap_ctr = 0;
    int          gap_n = 0;
    int          gap_bad = 0;

    logic [11:0] exp_coef [NCOEF];
    int          exp_used = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Serve blocks when asked, after resp_delay cycles of waiting.
    always @(negedge clk) begin
        if (resp_valid) begin
            resp_valid = 1'b0;
        end else if (rst_n && blk_req_o) begin
            if (wait_ctr < resp_delay) begin
                wait_ctr++;
            end else begin
                wait_ctr   = 0;
                resp_data  = (served < n_blocks) ? blocks[served] : {RATE{1'b1}};
                served++;
                resp_valid = 1'b1;
            end
        end
    end

    // Record outputs, done pulses and request gaps.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (coef_valid_o) begin
                if (got_n < NCOEF) begin
                    got_coef[got_n] = coef_o;
                    got_idx[got_n]  = coef_idx_o;
                end
                got_n++;
                last_coef_cyc = cyc;
            end
            if (done_o) begin
                done_n++;
                done_cyc = cyc;
            end
            if (!blk_req_o && !idle_o && !done_o) begin
                gap_ctr++;
            end else if (blk_req_o) begin
                if (gap_ctr > 0) begin
                    gap_n++;
                    if (gap_ctr != 2 * NGRP) gap_bad++;
                end
                gap_ctr = 0;
            end else begin
                gap_ctr = 0;
            end
        end
    end

    // Expected coefficient stream from the requirements (R3, R4, R5, R6, R8).
    task automatic build_expect();
        int n = 0;
        exp_used = 0;
        for (int b = 0; b < n_blocks; b++) begin
            if (n >= NCOEF) break;
            exp_used = b + 1;
            for (int g = 0; g < NGRP; g++) begin
                for (int h = 0; h < 2; h++) begin
                    logic [11:0] v;
                    v = blocks[b][24*g + 12*h +: 12];
                    if (n < NCOEF && v < Q) begin
                        exp_coef[n] = v;
                        n++;
                    end
                end
            end
        end
    endtask

    task automatic set_grp(input int b, input int g, input int d1, input int d2);
        blocks[b][24*g +: 24] = {12'(d2), 12'(d1)};
    endtask

    task automatic fill_accept(input int b, input int salt);
        for (int g = 0; g < NGRP; g++)
            set_grp(b, g, (g*37 + salt*11) % Q, (g*101 + salt*5 + 7) % Q);
    endtask

    task automatic fill_reject(input int b);
        blocks[b] = {RATE{1'b1}};
    endtask

    task automatic run_case(input string name, input int delay, input bit poke);
        int bad_c = 0;
        int bad_i = 0;
        int first_c = -1;
        @(posedge clk);
        got_n = 0; done_n = 0; gap_ctr = 0; gap_n = 0; gap_bad = 0;
        served = 0; wait_ctr = 0; resp_delay = delay;
        last_coef_cyc = -1; done_cyc = -2;
        build_expect();
        @(negedge clk);
        chk(idle_o == 1'b1, "R10", {name, " idle before start"}, int'(idle_o), 1);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(blk_req_o == 1'b1, "R2", {name, " request after start"}, int'(blk_req_o), 1);
        chk(idle_o == 1'b0, "R10", {name, " busy after start"}, int'(idle_o), 0);
        if (poke) begin
            repeat (40 + delay) @(negedge clk);
            start_i = 1'b1;
            spur_valid = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            spur_valid = 1'b0;
            repeat (3) @(negedge clk);
            spur_valid = 1'b1;
            @(negedge clk);
            spur_valid = 1'b0;
        end
        for (int k = 0; k < 6000; k++) begin
            if (done_n > 0) break;
            @(negedge clk);
        end
        @(negedge clk);
        chk(idle_o == 1'b1, "R10", {name, " idle after done"}, int'(idle_o), 1);
        repeat (30) @(negedge clk);
        chk(got_n == NCOEF, "R6", {name, " coefficient count"}, got_n, NCOEF);
        for (int i = 0; i < NCOEF && i < got_n; i++) begin
            if (got_coef[i] != exp_coef[i]) begin
                bad_c++;
                if (first_c < 0) first_c = i;
            end
            if (got_idx[i] != 8'(i)) bad_i++;
        end
        // R3 group order and R4 candidate split both show up in the values
        chk(bad_c == 0, "R4", {name, " coefficient values (R3 order)"},
            (first_c < 0) ? 0 : int'(got_coef[first_c]),
            (first_c < 0) ? 0 : int'(exp_coef[first_c]));
        chk(bad_i == 0, "R6", {name, " index sequence mismatches"}, bad_i, 0);
        chk(done_n == 1, "R8", {name, " done pulses"}, done_n, 1);
        chk(done_cyc == last_coef_cyc, "R8", {name, " done with last coefficient"},
            done_cyc, last_coef_cyc);
        chk(served == exp_used, "R8", {name, " blocks consumed"}, served, exp_used);
        chk(gap_bad == 0, "R7", {name, " walk length per block"}, gap_bad, 0);
        chk(gap_n == exp_used - 1, "R7", {name, " re-requests"}, gap_n, exp_used - 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(idle_o == 1'b1, "R1", "idle in reset", int'(idle_o), 1);
        chk(blk_req_o == 1'b0, "R1", "no request in reset", int'(blk_req_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(coef_valid_o == 1'b0, "R1", "no coefficient after reset", int'(coef_valid_o), 0);
        chk(done_o == 1'b0, "R1", "no done after reset", int'(done_o), 0);
        chk(idle_o == 1'b1, "R1", "idle after reset", int'(idle_o), 1);
    endtask

    task automatic t_all_accept();
        n_blocks = 3;
        for (int b = 0; b < 3; b++) fill_accept(b, b + 1);
        run_case("all_accept", 0, 1'b0);
    endtask

    task automatic t_random();
        int unsigned s = 32'h1234_5678;
        n_blocks = 5;
        for (int b = 0; b < 5; b++)
            for (int k = 0; k < RATE/8; k++) begin
                s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
                blocks[b][8*k +: 8] = s[7:0];
            end
        run_case("random_slow", 3, 1'b0);  // R2 delayed answer
    endtask

    task automatic t_reject_block();
        n_blocks = 4;
        fill_reject(0);
        for (int b = 1; b < 4; b++) fill_accept(b, b + 7);
        run_case("reject_first", 0, 1'b0);  // R5 R7
    endtask

    task automatic t_boundary();
        n_blocks = 6;
        for (int b = 0; b < 6; b++)
            for (int g = 0; g < NGRP; g++) set_grp(b, g, Q - 1, Q);  // R5 3328 kept, 3329 dropped
        run_case("boundary", 1, 1'b0);
    endtask

    task automatic t_drop_second();
        n_blocks = 3;
        for (int b = 0; b < 3; b++) begin
            fill_accept(b, b + 3);
            set_grp(b, 0, 4095, 5);
        end
        run_case("drop_second", 0, 1'b0);  // R8: final is an A candidate
    endtask

    task automatic t_end_on_block();
        n_blocks = 4;
        fill_accept(0, 2);
        fill_accept(1, 4);
        fill_accept(2, 6);
        for (int g = 0; g < 40; g++) set_grp(2, g, 4000, 3500);
        fill_accept(3, 9);
        run_case("end_on_block", 0, 1'b0);  // R8 R7 same-cycle
    endtask

    task automatic t_ignore();
        n_blocks = 3;
        for (int b = 0; b < 3; b++) fill_accept(b, b + 20);
        run_case("ignore_strays", 0, 1'b1);  // R9
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_all_accept();
        t_random();
        t_reject_block();
        t_boundary();
        t_drop_second();
        t_end_on_block();
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule